// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer. It sits beside a free-running counter that is built elsewhere. It receives the counter value, an overflow pulse and two status lines that say whether the counter is stopped and held in reset. The channel has three main uses. As an input capture unit it latches the counter when a chosen edge appears on the input pin. As an output compare unit it changes its output level when the counter equals a compare value. As a buffered compare unit it does the same, but a new compare value waits in a shadow register until the next counter overflow.

A 4-bit configuration word selects the behaviour. Bits [3:2] are the mode-select pair and bits [1:0] are the edge/action pair. When the edge/action pair is zero, the channel releases the pin to an alternate-function signal. In that state it also presets the level its own output will start from. A sticky flag records every capture or compare event until software clears it.

Top module: `tcc_channel`

## Requirements
- R1: When cfg bits [1:0] are 00, the pin is released: `pin_out` follows `alt_in` and `pin_dir` is 1, whatever the mode-select bits are.
- R2: While released, the channel output is preset to the inverse of cfg bit [2]: bit 2 = 0 presets high and bit 2 = 1 presets low. On leaving the released state, `pin_out` starts at that preset level.
- R3: With cfg bits [3:2] = 00, capture is armed on the edge given by bits [1:0]: 01 rising only, 10 falling only, 11 both. In this mode `pin_dir` is 0.
- R4: A qualified edge on `pin_in` causes the capture register to take the `cnt_val` present at the third rising clock edge after the pin change, and sets `chan_flag` at the same edge. In capture mode `chan_val` shows the capture register.
- R5: For the first two clock edges after capture is enabled, pin edges are ignored.
- R6: With cfg bits [3:2] = 01, or with bit 3 = 1, a compare match applies an action to `pin_out` at the clock edge where `cnt_val` equals the active compare value: 01 toggle, 10 drive low, 11 drive high. The same edge sets `chan_flag`.
- R7: `chan_flag` stays set until `flag_clr` is pulsed. When a new event and `flag_clr` occur in the same cycle, the flag stays set.
- R8: When bit 3 = 0, `val_wdata` becomes the active compare value one clock after `val_we`. When bit 3 = 1, the written value is held in a shadow register and becomes active only at the clock edge where `cnt_ovf` is high. Outside capture mode, `chan_val` shows the active compare value.
- R9: Cfg bits [3:2] are written only when both `cnt_stop` and `cnt_hold` are high. Bits [1:0] are written on every `cfg_we`.
- R10: A synchronous reset clears the configuration, the flag and both value registers, which releases the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Current counter value |
| cnt_ovf | input | 1 | Counter overflow pulse |
| cnt_stop | input | 1 | Counter is stopped |
| cnt_hold | input | 1 | Counter is held in reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 4 | Configuration word: [3:2] mode select, [1:0] edge/action |
| val_we | input | 1 | Write strobe for the compare value |
| val_wdata | input | 16 | Compare value to write |
| flag_clr | input | 1 | Clears the channel flag |
| pin_in | input | 1 | Asynchronous input pin |
| alt_in | input | 1 | Alternate-function level used while the pin is released |
| pin_out | output | 1 | Pin output level |
| pin_dir | output | 1 | 1 when the block drives the pin, 0 in capture mode |
| chan_flag | output | 1 | Sticky capture/compare event flag |
| chan_val | output | 16 | Capture register in capture mode, otherwise the active compare value |

## Verification
Two situations are hard to reach from the ports. The first is an edge that falls inside the two-clock blanking window. The bench reaches it by enabling capture and raising the pin in the same cycle, so the synchronised edge arrives while blanking is still active. The second is proof that a buffered compare value stays inactive until overflow. Here the bench holds the counter at the new value before the overflow pulse and confirms that no match occurs. After the overflow it confirms that `chan_val` changes and that the next match acts. Random capture edge codes, pin levels and compare actions run against a bench model of the edge and action encodings.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        MODE_RELEASE  = 2'd0,
        MODE_CAPTURE  = 2'd1,
        MODE_COMPARE  = 2'd2,
        MODE_BUFFERED = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic [1:0] sel;   // mode select pair
        logic [1:0] act;   // edge / action pair
    } chan_cfg_t;

    function automatic chan_mode_e decode_mode(input chan_cfg_t c);
        if (c.act == 2'b00)      return MODE_RELEASE;
        else if (c.sel[1])       return MODE_BUFFERED;
        else if (c.sel[0])       return MODE_COMPARE;
        else                     return MODE_CAPTURE;
    endfunction

    function automatic logic edge_hit(input logic [1:0] act, input logic rise, input logic fall);
        return (act[0] & rise) | (act[1] & fall);
    endfunction

    function automatic logic pin_action(input logic [1:0] act, input logic cur);
        case (act)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/tcc_cfg.sv
module tcc_cfg
    import tcc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                mode_unlock,
    output chan_cfg_t           cfg_q,
    output chan_mode_e          mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q.act <= cfg_wdata[1:0];
            if (mode_unlock)
                cfg_q.sel <= cfg_wdata[3:2];
        end
    end

    assign mode = decode_mode(cfg_q);

endmodule

// File: rtl/tcc_capture.sv
module tcc_capture
    import tcc_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_en,
    input  logic [1:0]       act,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] cnt_val,
    output logic [CNT_W-1:0] cap_q,
    output logic             cap_evt
);

    localparam int BW = $clog2(BLANK_CYCLES + 1);
    localparam logic [BW-1:0] BLANK_LOAD = BW'(BLANK_CYCLES);

    logic [SYNC_STAGES:0] chain;
    logic [BW-1:0]        blank_q;
    logic                 rise, fall;

    // synchronizer plus one history stage for edge detection
    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
    assign fall = ~chain[SYNC_STAGES-1] & chain[SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst || !cap_en)
            blank_q <= BLANK_LOAD;
        else if (blank_q != '0)
            blank_q <= blank_q - 1'b1;
    end

    assign cap_evt = cap_en && (blank_q == '0) && edge_hit(act, rise, fall);

    always_ff @(posedge clk) begin
        if (rst)
            cap_q <= '0;
        else if (cap_evt)
            cap_q <= cnt_val;
    end

endmodule

// File: rtl/tcc_compare.sv
module tcc_compare
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  chan_mode_e       mode,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    output logic [CNT_W-1:0] act_cmp,
    output logic             match
);

    logic [CNT_W-1:0] shd_q;
    logic             pend_q;
    logic             buffered;

    assign buffered = (mode == MODE_BUFFERED);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cmp <= '0;
            shd_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (buffered && cnt_ovf && pend_q) begin
                act_cmp <= shd_q;
                pend_q  <= 1'b0;
            end
            if (val_we && buffered) begin
                shd_q  <= val_wdata;
                pend_q <= 1'b1;
            end else if (val_we) begin
                act_cmp <= val_wdata;
            end
        end
    end

    assign match = (mode == MODE_COMPARE || buffered) && (cnt_val == act_cmp);

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             cnt_stop,
    input  logic             cnt_hold,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             flag_clr,
    input  logic             pin_in,
    input  logic             alt_in,
    output logic             pin_out,
    output logic             pin_dir,
    output logic             chan_flag,
    output logic [CNT_W-1:0] chan_val
);

    chan_cfg_t        cfg_q;
    chan_mode_e       mode_w;
    logic             cap_en;
    logic             cap_evt;
    logic             match_w;
    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] act_cmp;
    logic             out_q;

    tcc_cfg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .mode_unlock (cnt_stop & cnt_hold),
        .cfg_q       (cfg_q),
        .mode        (mode_w)
    );

    assign cap_en = (mode_w == MODE_CAPTURE);

    tcc_capture #(
        .CNT_W        (CNT_W),
        .SYNC_STAGES  (SYNC_STAGES),
        .BLANK_CYCLES (BLANK_CYCLES)
    ) u_cap (
        .clk     (clk),
        .rst     (rst),
        .cap_en  (cap_en),
        .act     (cfg_q.act),
        .pin_in  (pin_in),
        .cnt_val (cnt_val),
        .cap_q   (cap_q),
        .cap_evt (cap_evt)
    );

    tcc_compare #(
        .CNT_W (CNT_W)
    ) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode_w),
        .cnt_val   (cnt_val),
        .cnt_ovf   (cnt_ovf),
        .val_we    (val_we),
        .val_wdata (val_wdata),
        .act_cmp   (act_cmp),
        .match     (match_w)
    );

    // channel output level: preset while released, acted on by compare matches
    always_ff @(posedge clk) begin
        if (rst)
            out_q <= 1'b1;
        else if (mode_w == MODE_RELEASE)
            out_q <= ~cfg_q.sel[0];
        else if (match_w)
            out_q <= pin_action(cfg_q.act, out_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            chan_flag <= 1'b0;
        else if (cap_evt || match_w)
            chan_flag <= 1'b1;
        else if (flag_clr)
            chan_flag <= 1'b0;
    end

    assign pin_out  = (mode_w == MODE_RELEASE) ? alt_in : out_q;
    assign pin_dir  = (mode_w != MODE_CAPTURE);
    assign chan_val = cap_en ? cap_q : act_cmp;

endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk
    import tcc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_ovf,
    input logic             cnt_stop,
    input logic             cnt_hold,
    input logic             flag_clr,
    input logic             pin_out,
    input logic             chan_flag,
    input chan_cfg_t        cfg_q,
    input chan_mode_e       mode,
    input logic             cap_en,
    input logic             cap_evt,
    input logic             match_w,
    input logic [CNT_W-1:0] cap_q,
    input logic [CNT_W-1:0] act_cmp
);

    // R2: first cycle after leaving release shows the preset level
    assert_preset_level_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_RELEASE) ##1 (mode != MODE_RELEASE) |-> (pin_out == !$past(cfg_q.sel[0])));

    // R4: capture takes the counter and raises the flag
    assert_capture_value_R4: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> (cap_q == $past(cnt_val)) && chan_flag);

    // R5: no event in the cycle capture becomes enabled, nor the next
    assert_blank_first_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_en) |-> !cap_evt);
    assert_blank_second_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_en) |=> !cap_evt);

    // R6: a match raises the flag
    assert_match_flag_R6: assert property (@(posedge clk) disable iff (rst)
        match_w |=> chan_flag);

    // R7: flag is sticky without a clear
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        chan_flag && !flag_clr |=> chan_flag);

    // R8: buffered active compare moves only on overflow
    assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_BUFFERED) && !cnt_ovf |=> $stable(act_cmp));

    // R9: mode select locked while the counter runs
    assert_mode_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !(cnt_stop && cnt_hold) |=> $stable(cfg_q.sel));

    // R10: reset releases the pin and clears the flag
    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (cfg_q.act == 2'b00) && !chan_flag);

endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .cnt_ovf   (cnt_ovf),
    .cnt_stop  (cnt_stop),
    .cnt_hold  (cnt_hold),
    .flag_clr  (flag_clr),
    .pin_out   (pin_out),
    .chan_flag (chan_flag),
    .cfg_q     (cfg_q),
    .mode      (mode_w),
    .cap_en    (cap_en),
    .cap_evt   (cap_evt),
    .match_w   (match_w),
    .cap_q     (cap_q),
    .act_cmp   (act_cmp)
);

// File: tb/tcc_channel_test.sv
`timescale 1ns/1ps
module tcc_channel_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = 16'hFFFF;
    logic        cnt_ovf = 1'b0;
    logic        cnt_stop = 1'b0;
    logic        cnt_hold = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_wdata = 4'h0;
    logic        val_we = 1'b0;
    logic [15:0] val_wdata = 16'h0;
    logic        flag_clr = 1'b0;
    logic        pin_in = 1'b0;
    logic        alt_in = 1'b0;
    logic        pin_out, pin_dir, chan_flag;
    logic [15:0] chan_val;

    int checks = 0;
    int errors = 0;
    logic        exp_pin;
    logic [15:0] exp_val;
    logic [15:0] cmp_a, cmp_b;

    always #10 clk = ~clk;   // 50 MHz

    tcc_channel uut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .cnt_stop(cnt_stop), .cnt_hold(cnt_hold), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .val_we(val_we), .val_wdata(val_wdata),
        .flag_clr(flag_clr), .pin_in(pin_in), .alt_in(alt_in),
        .pin_out(pin_out), .pin_dir(pin_dir), .chan_flag(chan_flag),
        .chan_val(chan_val)
    );

    function automatic logic m_action(input logic [1:0] code, input logic cur);
        if (code == 2'b01) return ~cur;
        if (code == 2'b10) return 1'b0;
        if (code == 2'b11) return 1'b1;
        return cur;
    endfunction

    function automatic logic m_hit(input logic [1:0] code, input logic o, input logic n);
        return (code[0] && !o && n) || (code[1] && o && !n);
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [3:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] v);
        cnt_stop = 1'b1; cnt_hold = 1'b1;
        write_cfg(v);
        cnt_stop = 1'b0; cnt_hold = 1'b0;
    endtask

    task automatic write_val(input logic [15:0] v);
        val_we = 1'b1; val_wdata = v;
        step();
        val_we = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst = 1'b0;
        step();

        // R10 reset state, R1 release
        chk("R10 flag", chan_flag, 0);
        chk("R10 val", chan_val, 0);
        chk("R1 dir", pin_dir, 1);
        alt_in = 1'b1; #1;
        chk("R1 alt high", pin_out, 1);
        alt_in = 1'b0; #1;
        chk("R1 alt low", pin_out, 0);
        set_mode(4'b1000);  // mode bits set, edge pair 00: still released
        alt_in = 1'b1; #1;
        chk("R1 released with mode bits", pin_out, 1);

        // R2 preset levels
        set_mode(4'b0000); step();
        set_mode(4'b0110);
        chk("R2 preset high", pin_out, 1);
        set_mode(4'b0100); step();
        set_mode(4'b0101);
        chk("R2 preset low", pin_out, 0);
        exp_pin = 1'b0;

        // R6 directed toggle, R8 unbuffered write
        write_val(16'd100);
        chk("R8 unbuffered write", chan_val, 100);
        cnt_val = 16'd100; step(); cnt_val = 16'hFFFF;
        exp_pin = ~exp_pin;
        chk("R6 toggle", pin_out, exp_pin);
        chk("R6 flag", chan_flag, 1);

        // R6 random compare actions, R7 clear
        for (int i = 0; i < 12; i++) begin
            logic [1:0] code;
            logic [15:0] cmp;
            code = 2'($urandom_range(1, 3));
            cmp  = 16'($urandom_range(0, 16'hFFF0));
            set_mode({2'b01, code});
            write_val(cmp);
            clr_flag();
            chk("R7 cleared", chan_flag, 0);
            cnt_val = cmp; step(); cnt_val = 16'hFFFF;
            exp_pin = m_action(code, exp_pin);
            chk("R6 action", pin_out, exp_pin);
            chk("R6 flag on match", chan_flag, 1);
            cmp_a = cmp;
        end

        // R7 event wins over clear
        set_mode(4'b0101);
        cnt_val = cmp_a; flag_clr = 1'b1; step(); flag_clr = 1'b0; cnt_val = 16'hFFFF;
        exp_pin = ~exp_pin;
        chk("R7 set wins", chan_flag, 1);
        clr_flag();
        chk("R7 clear", chan_flag, 0);

        // R8 buffered compare
        for (int r = 0; r < 2; r++) begin
            set_mode(4'b1101);
            cmp_b = cmp_a ^ 16'h0100;
            if (cmp_b >= 16'hFFF0) cmp_b = 16'h0042;
            write_val(cmp_b);
            step(); step();
            chk("R8 shadow held", chan_val, cmp_a);
            cnt_val = cmp_b; step(); cnt_val = 16'hFFFF;
            chk("R8 no early match flag", chan_flag, 0);
            chk("R8 no early match pin", pin_out, exp_pin);
            cnt_ovf = 1'b1; step(); cnt_ovf = 1'b0;
            chk("R8 loaded on overflow", chan_val, cmp_b);
            cnt_val = cmp_b; step(); cnt_val = 16'hFFFF;
            exp_pin = ~exp_pin;
            chk("R8 buffered match pin", pin_out, exp_pin);
            chk("R6 buffered flag", chan_flag, 1);
            clr_flag();
            cmp_a = cmp_b;
        end

        // R5 blanking: enable capture and raise the pin together
        cnt_stop = 1'b1; cnt_hold = 1'b1;
        cfg_we = 1'b1; cfg_wdata = 4'b0001; pin_in = 1'b1; cnt_val = 16'h1234;
        step();
        cfg_we = 1'b0; cnt_stop = 1'b0; cnt_hold = 1'b0;
        step(); step(); step();
        chk("R5 blanked edge", chan_flag, 0);
        chk("R3 dir input", pin_dir, 0);
        chk("R4 capture reg untouched", chan_val, 0);

        // R3 rising-only ignores a fall
        pin_in = 1'b0; cnt_val = 16'h2222;
        step(); step(); step();
        chk("R3 fall ignored", chan_flag, 0);
        pin_in = 1'b1; cnt_val = 16'h3333;
        step(); step(); step();
        chk("R3 rise flag", chan_flag, 1);
        chk("R4 rise value", chan_val, 16'h3333);
        exp_val = 16'h3333;

        // R3/R4 random capture edges
        for (int i = 0; i < 24; i++) begin
            logic [1:0] code;
            logic np, op;
            logic [15:0] cv;
            code = 2'($urandom_range(1, 3));
            set_mode({2'b00, code});
            clr_flag();
            op = pin_in;
            np = 1'($urandom_range(0, 1));
            cv = 16'($urandom);
            cnt_val = cv; pin_in = np;
            step(); step(); step();
            if (m_hit(code, op, np)) exp_val = cv;
            chk("R3 edge flag", chan_flag, m_hit(code, op, np));
            chk("R4 capture value", chan_val, exp_val);
        end

        // R9 mode write ignored while running, edge pair taken
        set_mode(4'b0001);
        clr_flag();
        write_cfg(4'b0111);
        chk("R9 still capture", pin_dir, 0);
        cnt_val = 16'h5A5A; pin_in = ~pin_in;
        step(); step(); step();
        // both-edge code now active: either edge direction captures
        chk("R9 edge pair applied flag", chan_flag, 1);
        chk("R9 edge pair applied value", chan_val, 16'h5A5A);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule